// File: doc/BRIEF.md
# Even/Odd Interlace Subchannel Controller

This block is the per-subchannel sequencer that decides which of two fixed control words steers each data transfer. Every subchannel owns a pair of words. One sits at an even address and the other at the odd address directly above it. A program loads a 12-bit control word. That load picks the starting word, arms the zero-count and end-of-record interrupts, and enables cycling. The load also starts the subchannel.

While the subchannel is active, the transfer engine pulses `zero_cnt_i` each time the selected word's count runs out. On the even word, the controller always moves on to the odd word. On the odd word, it goes back to the even word if cycling is enabled, and otherwise it stops. The device can end the transfer at any time with `eor_i`. The program can stop it with `term_i`. The block does not move any data.

Top module: `interlace_pair_ctrl`

## Requirements
- R1: After reset, `active_o`, `zc_irq_o` and `eor_irq_o` are 0 and `word_addr_o` holds the even address of the pair.
- R2: A cycle with `ctrl_we_i` high sets `active_o` on the next edge. Control fields are `ctrl_i[0]` start on odd (1) or even (0), `ctrl_i[1]` cycle enable, `ctrl_i[2]` zero-count interrupt arm, and `ctrl_i[3]` end-of-record interrupt arm. `ctrl_i[11:4]` have no effect.
- R3: A zero-count pulse while active on the even word selects the odd word on the next edge, and the subchannel stays active.
- R4: A zero-count pulse while active on the odd word with cycling enabled selects the even word, and the subchannel stays active.
- R5: A zero-count pulse while active on the odd word with cycling disabled clears `active_o`.
- R6: `zc_irq_o` pulses for one cycle after a zero-count pulse only when zero-count is armed. With cycling enabled it pulses at every switch. With cycling disabled it pulses only when the odd word runs out.
- R7: `eor_i` while active clears `active_o`. It pulses `eor_irq_o` one cycle later only if end-of-record is armed.
- R8: `term_i` clears `active_o` on the next edge. It takes priority over a load, `eor_i` and `zero_cnt_i` in the same cycle, and it raises no interrupt.
- R9: While inactive, `zero_cnt_i` and `eor_i` are ignored: the word address does not change and no interrupt pulses.
- R10: `word_addr_o` is `SUB_NUM` with bit 0 replaced by the selected word (0 even, 1 odd).
- R11: `eor_i` and `zero_cnt_i` together while active terminate the transfer, leave the word selection unchanged, and raise no zero-count interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Load the control word and start the subchannel |
| ctrl_i | input | 12 | Control word |
| zero_cnt_i | input | 1 | Count of the selected word reached zero |
| eor_i | input | 1 | End-of-record from the device |
| term_i | input | 1 | Program terminate command |
| word_addr_o | output | ADDR_W | Address of the selected control word |
| active_o | output | 1 | Subchannel is transferring |
| zc_irq_o | output | 1 | Zero-count interrupt pulse |
| eor_irq_o | output | 1 | End-of-record interrupt pulse |

## Verification
The bench builds the block with `ADDR_W` = 8 and `SUB_NUM` = 46. The even and odd addresses are therefore 46 and 47, which differ only in bit 0. Because the base address has upper bits set, any corruption of the base is visible at the port. Covering all four arm/cycle combinations reaches every branch of the switch and interrupt decision, including same-cycle collisions between a terminate, an end-of-record and a zero count.

// File: rtl/interlace_pkg.sv
package interlace_pkg;
  localparam int unsigned CTRL_W    = 12;
  localparam int unsigned BIT_ODD   = 0;
  localparam int unsigned BIT_CYC   = 1;
  localparam int unsigned BIT_ZCARM = 2;
  localparam int unsigned BIT_ERARM = 3;

  typedef struct packed {
    logic er_arm;
    logic zc_arm;
    logic cyc;
    logic start_odd;
  } ilv_cfg_t;

  function automatic ilv_cfg_t decode_cfg(input logic [CTRL_W-1:0] w);
    ilv_cfg_t c;
    c.er_arm    = w[BIT_ERARM];
    c.zc_arm    = w[BIT_ZCARM];
    c.cyc       = w[BIT_CYC];
    c.start_odd = w[BIT_ODD];
    return c;
  endfunction
endpackage

// File: rtl/interlace_cfg.sv
module interlace_cfg
  import interlace_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output ilv_cfg_t          cfg_o
);
  ilv_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= decode_cfg(ctrl_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/interlace_sel.sv
module interlace_sel
  import interlace_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  logic     load_odd_i,
  input  ilv_cfg_t cfg_i,
  input  logic     zero_i,
  input  logic     eor_i,
  input  logic     term_i,
  output logic     active_o,
  output logic     odd_o,
  output logic     zc_event_o,
  output logic     eor_event_o
);
  logic active_q, odd_q;
  logic go, eor_hit, zc_hit;

  // terminate beats load; load beats device events
  assign go      = active_q & ~term_i & ~load_i;
  assign eor_hit = go & eor_i;
  assign zc_hit  = go & ~eor_i & zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      odd_q    <= 1'b0;
    end else if (term_i) begin
      active_q <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      odd_q    <= load_odd_i;
    end else if (eor_hit) begin
      active_q <= 1'b0;
    end else if (zc_hit) begin
      if (!odd_q)         odd_q    <= 1'b1;
      else if (cfg_i.cyc) odd_q    <= 1'b0;
      else                active_q <= 1'b0;
    end
  end

  // even-word exhaustion only interrupts in cycle mode
  assign zc_event_o  = zc_hit & cfg_i.zc_arm & (odd_q | cfg_i.cyc);
  assign eor_event_o = eor_hit & cfg_i.er_arm;
  assign active_o    = active_q;
  assign odd_o       = odd_q;
endmodule

// File: rtl/interlace_irq.sv
module interlace_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zc_event_i,
  input  logic eor_event_i,
  output logic zc_irq_o,
  output logic eor_irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zc_irq_o  <= 1'b0;
      eor_irq_o <= 1'b0;
    end else begin
      zc_irq_o  <= zc_event_i;
      eor_irq_o <= eor_event_i;
    end
  end
endmodule

// File: rtl/interlace_pair_ctrl.sv
module interlace_pair_ctrl
  import interlace_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SUB_NUM = 46
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              zero_cnt_i,
  input  logic              eor_i,
  input  logic              term_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              active_o,
  output logic              zc_irq_o,
  output logic              eor_irq_o
);
  localparam logic [ADDR_W-1:0] PAIR_BASE = {SUB_NUM[ADDR_W-1:1], 1'b0};

  ilv_cfg_t cfg;
  logic     odd, zc_event, eor_event;

  interlace_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctrl_we_i),
    .ctrl_i (ctrl_i),
    .cfg_o  (cfg)
  );

  interlace_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ctrl_we_i),
    .load_odd_i  (ctrl_i[BIT_ODD]),
    .cfg_i       (cfg),
    .zero_i      (zero_cnt_i),
    .eor_i       (eor_i),
    .term_i      (term_i),
    .active_o    (active_o),
    .odd_o       (odd),
    .zc_event_o  (zc_event),
    .eor_event_o (eor_event)
  );

  interlace_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .zc_event_i  (zc_event),
    .eor_event_i (eor_event),
    .zc_irq_o    (zc_irq_o),
    .eor_irq_o   (eor_irq_o)
  );

  assign word_addr_o = PAIR_BASE | {{(ADDR_W-1){1'b0}}, odd};
endmodule

// File: rtl/interlace_pair_ctrl_chk.sv
module interlace_pair_ctrl_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              zero_cnt_i,
  input logic              eor_i,
  input logic              term_i,
  input logic [ADDR_W-1:0] word_addr_o,
  input logic              active_o,
  input logic              zc_irq_o,
  input logic              eor_irq_o
);
  assert_load_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !term_i) |=> active_o);

  assert_zc_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_cnt_i && !(active_o && !term_i && !ctrl_we_i && !eor_i)) |=> !zc_irq_o);

  assert_eor_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eor_i && active_o && !term_i && !ctrl_we_i) |=> !eor_irq_o);

  assert_term_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i |=> (!active_o && !zc_irq_o && !eor_irq_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !ctrl_we_i) |=> (!active_o && $stable(word_addr_o)));

  assert_eor_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eor_i && active_o && !ctrl_we_i) |=> !active_o);
endmodule

bind interlace_pair_ctrl interlace_pair_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .zero_cnt_i  (zero_cnt_i),
  .eor_i       (eor_i),
  .term_i      (term_i),
  .word_addr_o (word_addr_o),
  .active_o    (active_o),
  .zc_irq_o    (zc_irq_o),
  .eor_irq_o   (eor_irq_o)
);

// File: tb/interlace_pair_ctrl_test.sv
module interlace_pair_ctrl_test;
  localparam int unsigned ADDR_W = 8;
  localparam logic [7:0] EVEN = 8'd46;
  localparam logic [7:0] ODD  = 8'd47;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [11:0] ctrl_i = '0;
  logic        zero_cnt_i = 1'b0, eor_i = 1'b0, term_i = 1'b0;
  logic [7:0]  word_addr_o;
  logic        active_o, zc_irq_o, eor_irq_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  interlace_pair_ctrl #(.ADDR_W(ADDR_W), .SUB_NUM(8'd46)) uut (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_i, .zero_cnt_i, .eor_i, .term_i,
    .word_addr_o, .active_o, .zc_irq_o, .eor_irq_o
  );

  task automatic step(input logic we, input logic [11:0] c,
                      input logic z, input logic e, input logic t);
    ctrl_we_i = we; ctrl_i = c; zero_cnt_i = z; eor_i = e; term_i = t;
    @(negedge clk_i);
    ctrl_we_i = 0; ctrl_i = '0; zero_cnt_i = 0; eor_i = 0; term_i = 0;
  endtask

  task automatic chk(input string req, input logic [7:0] a, input logic act,
                     input logic zc, input logic er);
    checks++;
    if (word_addr_o !== a || active_o !== act || zc_irq_o !== zc || eor_irq_o !== er) begin
      errors++;
      $display("FAIL %s: got addr=%0d act=%b zc=%b eor=%b expected addr=%0d act=%b zc=%b eor=%b",
               req, word_addr_o, active_o, zc_irq_o, eor_irq_o, a, act, zc, er);
    end
  endtask

  task automatic t_reset;
    chk("R1", EVEN, 0, 0, 0);
  endtask

  task automatic t_no_cycle;
    step(1, 12'h004, 0, 0, 0); chk("R2", EVEN, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R3 R6", ODD, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R5 R6", ODD, 0, 1, 0);
    step(0, '0, 1, 1, 0);      chk("R9", ODD, 0, 0, 0);
  endtask

  task automatic t_cycle;
    step(1, 12'h006, 0, 0, 0); chk("R2 R10", EVEN, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R6 R3", ODD, 1, 1, 0);
    step(0, '0, 1, 0, 0);      chk("R4 R6", EVEN, 1, 1, 0);
    step(0, '0, 0, 0, 0);      chk("R6 pulse", EVEN, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R4", ODD, 1, 1, 0);
    step(0, '0, 0, 0, 1);      chk("R8", ODD, 0, 0, 0);
  endtask

  task automatic t_start_odd;
    step(1, 12'h003, 0, 0, 0); chk("R2 R10", ODD, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R4 R6", EVEN, 1, 0, 0);
    step(0, '0, 0, 0, 1);      chk("R8", EVEN, 0, 0, 0);
  endtask

  task automatic t_eor;
    step(1, 12'h008, 0, 0, 0); chk("R2", EVEN, 1, 0, 0);
    step(0, '0, 0, 1, 0);      chk("R7", EVEN, 0, 0, 1);
    step(0, '0, 0, 0, 0);      chk("R7 pulse", EVEN, 0, 0, 0);
    step(1, 12'h000, 0, 0, 0); chk("R2", EVEN, 1, 0, 0);
    step(0, '0, 0, 1, 0);      chk("R7 unarmed", EVEN, 0, 0, 0);
  endtask

  task automatic t_collide;
    step(1, 12'h00E, 0, 0, 0); chk("R2", EVEN, 1, 0, 0);
    step(0, '0, 1, 1, 0);      chk("R11", EVEN, 0, 0, 1);
    step(1, 12'h00F, 0, 0, 0); chk("R2", ODD, 1, 0, 0);
    step(0, '0, 1, 1, 1);      chk("R8", ODD, 0, 0, 0);
    step(0, '0, 1, 1, 0);      chk("R9", ODD, 0, 0, 0);
    step(1, 12'h000, 0, 0, 1); chk("R8 load", ODD, 0, 0, 0);
  endtask

  task automatic t_upper_bits;
    step(1, 12'hFF0, 0, 0, 0); chk("R2 upper", EVEN, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R2 upper", ODD, 1, 0, 0);
    step(0, '0, 1, 0, 0);      chk("R2 upper", ODD, 0, 0, 0);
    step(0, '0, 0, 1, 0);      chk("R9", ODD, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_cycle();
    t_cycle();
    t_start_odd();
    t_eor();
    t_collide();
    t_upper_bits();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule